// File: doc/BRIEF.md
# Scan Register Access Port

This block lets a debug host read and write a register bank through one shift register. The host selects the shift path with a scan instruction. It then drives the usual capture, shift and update strobes, which come from an external TAP controller. Each scan frame holds three fields, from the serial-in end outward: a direction flag at the top, a register address below it, and a data word at the least-significant end. Bits leave on `tdo` least-significant bit first.

On update, a frame with the direction flag set writes its data word to the addressed register. A frame with the flag clear requests a read. Read data is pipelined by one scan: the capture of the next scan loads the fetched word into the data field. A host that wants a value therefore issues a read and then a second scan to collect it. The second scan can be a harmless read of address 0, so that a register with a read side effect is not fetched twice.

The bank sits outside this block. The block drives a one-cycle write or read strobe with an address and write data, and it samples the bank's combinational read data.

Top module: `scan_reg_port`

## Requirements
- R1: While `sel` is high and `shift_en` is high (with `cap_en` low), the frame moves one bit toward the LSB each cycle. `tdi` enters at bit FRAME_W-1 and `tdo` always shows bit 0.
- R2: An update (`sel` and `upd_en` high) of a frame whose direction bit (bit FRAME_W-1) is 1 and whose address is in the map produces exactly one `bus_wr` pulse. The pulse comes in the cycle after the update and carries the frame's address (bits DATA_W..DATA_W+ADDR_W-1) and data (bits 0..DATA_W-1).
- R3: An update of an in-map frame whose direction bit is 0 produces exactly one `bus_rd` pulse, in the cycle after the update, with the frame's address. `bus_wr` and `bus_rd` are never high together.
- R4: A capture (`sel` and `cap_en` high) loads the data field with the word fetched by the read of the previous scan. The address field and direction field are loaded with zeros.
- R5: Addresses at or above NUM_REGS raise no strobe, and a read of such an address yields zero at the next capture.
- R6: When the previous scan was a write, the next capture loads zero into the data field.
- R7: While `sel` is low, all three strobes are ignored: no bus strobe, and the held read result is unchanged.
- R8: After reset, the frame and the held read result are zero, so `tdo` is 0 and no strobe is active.
- R9: Capture and shift never raise a bus strobe. A register with a read side effect is therefore touched once per read update and no entry is skipped.
- R10: Strobe priority when several are high is capture, then shift, then update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Access instruction selected |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Register write data |
| bus_rdata | input | DATA_W | Register read data, combinational from bank |

## Verification
The bench builds the port with a 32-bit data field, a 7-bit address and NUM_REGS set to 6. This leaves addresses 6, 7 and 127 outside the map, so out-of-map reads and writes are exercised next to in-map ones. A bank model with a fixed identity word at address 0 and a read-advancing data source at address 4 shows that each read update advances the source exactly once. It also shows that the identity read used to collect a result costs nothing.

// File: rtl/scanport_pkg.sv
package scanport_pkg;
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_CAPTURE = 2'd1,
        ACT_SHIFT   = 2'd2,
        ACT_UPDATE  = 2'd3
    } scan_act_e;

    function automatic scan_act_e pick_act(input logic sel, input logic cap,
                                           input logic shf, input logic upd);
        if (!sel)     return ACT_NONE;
        else if (cap) return ACT_CAPTURE;
        else if (shf) return ACT_SHIFT;
        else if (upd) return ACT_UPDATE;
        else          return ACT_NONE;
    endfunction
endpackage

// File: rtl/scan_shifter.sv
module scan_shifter
    import scanport_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FRAME_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  scan_act_e          act,
    input  logic               tdi,
    input  logic [DATA_W-1:0]  cap_data,
    output logic [FRAME_W-1:0] frame,
    output logic               tdo
);
    typedef struct packed {
        logic [FRAME_W-1:0] bits;
    } shf_state_t;

    shf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_CAPTURE: st_d.bits = FRAME_W'(cap_data);
            ACT_SHIFT:   st_d.bits = {tdi, st_q.bits[FRAME_W-1:1]};
            default:     st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame = st_q.bits;
    assign tdo   = st_q.bits[0];
endmodule

// File: rtl/access_decode.sv
module access_decode
    import scanport_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 8,
    parameter int FRAME_W  = DATA_W + ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  scan_act_e          act,
    input  logic [FRAME_W-1:0] frame,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_wr,
    output logic               bus_rd,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  rd_result
);
    localparam int            DIR_POS = FRAME_W - 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              pend;
        logic              pend_ok;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] hold;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    logic              f_dir;
    logic              f_ok;

    always_comb begin
        f_addr = frame[DATA_W +: ADDR_W];
        f_data = frame[DATA_W-1:0];
        f_dir  = frame[DIR_POS];
        f_ok   = ({1'b0, f_addr} < LIMIT);

        st_d      = st_q;
        st_d.wr   = 1'b0;
        st_d.rd   = 1'b0;
        st_d.pend = 1'b0;

        if (st_q.pend)
            st_d.hold = st_q.pend_ok ? bus_rdata : '0;

        if (act == ACT_UPDATE) begin
            st_d.addr  = f_addr;
            st_d.wdata = f_data;
            if (f_dir) begin
                st_d.wr   = f_ok;
                st_d.hold = '0;
            end else begin
                st_d.rd      = f_ok;
                st_d.pend    = 1'b1;
                st_d.pend_ok = f_ok;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_wr    = st_q.wr;
    assign bus_rd    = st_q.rd;
    assign bus_addr  = st_q.addr;
    assign bus_wdata = st_q.wdata;
    assign rd_result = st_q.hold;
endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
    import scanport_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              upd_en,
    input  logic              tdi,
    output logic              tdo,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int FRAME_W = DATA_W + ADDR_W + 1;

    scan_act_e          act;
    logic [FRAME_W-1:0] frame_w;
    logic [DATA_W-1:0]  result_w;

    always_comb act = pick_act(sel, cap_en, shift_en, upd_en);

    scan_shifter #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .tdi      (tdi),
        .cap_data (result_w),
        .frame    (frame_w),
        .tdo      (tdo)
    );

    access_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
                    .FRAME_W(FRAME_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .frame     (frame_w),
        .bus_rdata (bus_rdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rd_result (result_w)
    );
endmodule

// File: rtl/scan_reg_port_chk.sv
module scan_reg_port_chk #(
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              cap_en,
    input logic              shift_en,
    input logic              upd_en,
    input logic              tdo,
    input logic              next_bit,
    input logic              fr_dir,
    input logic [ADDR_W-1:0] fr_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr
);
    logic do_upd;
    assign do_upd = sel && upd_en && !cap_en && !shift_en;

    // R1: a shift step exposes the next frame bit on tdo
    p_shift_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift_en && !cap_en) |=> (tdo == $past(next_bit)));

    // R2: a write strobe follows a write update of the same address
    p_wr_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> ($past(do_upd) && $past(fr_dir) && (bus_addr == $past(fr_addr))));

    // R3: a read strobe follows a read update; strobes are exclusive
    p_rd_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> ($past(do_upd) && !$past(fr_dir) && (bus_addr == $past(fr_addr))));

    p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R5: no strobe ever reaches an address outside the map
    p_in_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> (int'(bus_addr) < NUM_REGS));

    // R7: deselected strobes raise nothing on the bus
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (!bus_wr && !bus_rd));

    // R9: capture and shift never touch the bank
    p_no_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && (cap_en || shift_en)) |=> (!bus_wr && !bus_rd));
endmodule

bind scan_reg_port scan_reg_port_chk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .upd_en   (upd_en),
    .tdo      (tdo),
    .next_bit (frame_w[1]),
    .fr_dir   (frame_w[FRAME_W-1]),
    .fr_addr  (frame_w[DATA_W +: ADDR_W]),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr)
);

// File: tb/scan_reg_port_tb.sv
module scan_reg_port_tb;
    localparam int DW = 32;
    localparam int AW = 7;
    localparam int NREG = 6;
    localparam int FW = DW + AW + 1;
    localparam logic [31:0] ID_WORD = 32'h5A3C_0001;
    localparam int NVEC = 16;

    // {dir, addr, data, expected capture of this scan}
    localparam logic [71:0] VEC [NVEC] = '{
        {1'b1, 7'd1,   32'h1111_1111, 32'h0},
        {1'b1, 7'd2,   32'h2222_2222, 32'h0},
        {1'b0, 7'd1,   32'h0,         32'h0},
        {1'b0, 7'd2,   32'h0,         32'h1111_1111},
        {1'b0, 7'd0,   32'h0,         32'h2222_2222},
        {1'b1, 7'd7,   32'hDEAD_BEEF, ID_WORD},
        {1'b0, 7'd7,   32'h0,         32'h0},
        {1'b0, 7'd4,   32'h0,         32'h0},
        {1'b0, 7'd0,   32'h0,         32'hA000_0000},
        {1'b0, 7'd4,   32'h0,         ID_WORD},
        {1'b0, 7'd4,   32'h0,         32'hA000_0001},
        {1'b0, 7'd5,   32'h0,         32'hA000_0002},
        {1'b1, 7'd4,   32'hCAFE_F00D, 32'h0},
        {1'b0, 7'd3,   32'h0,         32'h0},
        {1'b0, 7'd127, 32'h0,         32'h0},
        {1'b0, 7'd1,   32'h0,         32'h0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, tdi = 1'b0;
    logic tdo, bus_wr, bus_rd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    int checks = 0;
    int errors = 0;
    int rd_count = 0;
    int bad_strobes = 0;
    logic [31:0] bank [NREG];
    logic [31:0] ptr = 32'h0;

    always #2.5 clk = ~clk;

    scan_reg_port #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cap_en(cap_en), .shift_en(shift_en),
        .upd_en(upd_en), .tdi(tdi), .tdo(tdo), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // bank model: 0 = identity, 4 = advancing data source, others plain
    always_comb begin
        if (int'(bus_addr) >= NREG)  bus_rdata = 32'hFFFF_FFFF;
        else if (bus_addr == 7'd0)   bus_rdata = ID_WORD;
        else if (bus_addr == 7'd4)   bus_rdata = 32'hA000_0000 + ptr;
        else                         bus_rdata = bank[bus_addr[2:0]];
    end

    initial for (int i = 0; i < NREG; i++) bank[i] = '0;

    always @(posedge clk) begin
        if ((bus_wr || bus_rd) && int'(bus_addr) >= NREG) bad_strobes++;
        if (bus_rd) rd_count++;
        if (bus_rd && bus_addr == 7'd4) ptr <= ptr + 1;
        if (bus_wr && int'(bus_addr) < NREG && bus_addr != 7'd0 && bus_addr != 7'd4)
            bank[bus_addr[2:0]] <= bus_wdata;
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    logic          s_wr, s_rd;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_wdata;

    task automatic do_scan(input logic en, input logic dir, input logic [AW-1:0] a,
                           input logic [DW-1:0] w, output logic [FW-1:0] got);
        logic [FW-1:0] fin;
        fin = {dir, a, w};
        @(negedge clk);
        sel = en; cap_en = 1'b1;
        @(negedge clk);
        cap_en = 1'b0; shift_en = 1'b1;
        for (int i = 0; i < FW; i++) begin
            got[i] = tdo;
            tdi = fin[i];
            @(negedge clk);
        end
        shift_en = 1'b0; upd_en = 1'b1;
        @(negedge clk);
        upd_en = 1'b0;
        s_wr = bus_wr; s_rd = bus_rd; s_addr = bus_addr; s_wdata = bus_wdata;
        @(negedge clk);
        @(negedge clk);
        sel = 1'b0;
    endtask

    logic done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] got;
        int rc;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 tdo", 64'(tdo), 64'h0);
        check("R8 strobes", 64'({bus_wr, bus_rd}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            logic          dir;
            logic [AW-1:0] a;
            logic [DW-1:0] w, e;
            logic          ok;
            {dir, a, w, e} = VEC[v];
            ok = int'(a) < NREG;
            do_scan(1'b1, dir, a, w, got);
            check("R4/R5/R6 capture data", 64'(got[DW-1:0]), 64'(e));
            check("R4 capture upper fields", 64'(got[FW-1:DW]), 64'h0);
            if (!ok)
                check("R5 no strobe", 64'({s_wr, s_rd}), 64'h0);
            else if (dir)
                check("R2 write strobe", {s_wr, s_rd, 15'(s_addr), s_wdata},
                      {1'b1, 1'b0, 15'(a), w});
            else
                check("R3 read strobe", 64'({s_wr, s_rd, s_addr}), 64'({1'b0, 1'b1, a}));
        end
        check("R5 out-of-map strobes", 64'(bad_strobes), 64'h0);

        // R7: deselected write attempt, then read back address 1
        rc = rd_count;
        do_scan(1'b0, 1'b1, 7'd1, 32'h0, got);
        check("R7 no strobe when deselected", 64'({s_wr, s_rd}), 64'h0);
        check("R7 no read when deselected", 64'(rd_count), 64'(rc));
        do_scan(1'b1, 1'b0, 7'd1, 32'h0, got);
        do_scan(1'b1, 1'b0, 7'd0, 32'h0, got);
        check("R7 register kept", 64'(got[DW-1:0]), 64'h1111_1111);

        // R9: captures alone touch nothing and repeat the same word
        rc = rd_count;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); sel = 1'b1; cap_en = 1'b1;
            @(negedge clk); cap_en = 1'b0;
            check("R9 capture repeat", 64'(tdo), 64'(ID_WORD[0]));
        end
        check("R9 no read strobe", 64'(rd_count), 64'(rc));

        // R10: capture wins over shift and update in the same cycle
        @(negedge clk); cap_en = 1'b1; shift_en = 1'b1; upd_en = 1'b1; tdi = 1'b0;
        @(negedge clk); cap_en = 1'b0; shift_en = 1'b0; upd_en = 1'b0;
        check("R10 capture priority", 64'({tdo, bus_wr, bus_rd}), {61'h0, ID_WORD[0], 2'b00});

        // R1: pattern shifted through without update reappears on tdo
        begin
            logic [FW-1:0] pat, seen;
            pat = {1'b1, 7'h35, 32'h9C3E_71A5};
            @(negedge clk); shift_en = 1'b1;
            for (int i = 0; i < FW; i++) begin tdi = pat[i]; @(negedge clk); end
            for (int i = 0; i < FW; i++) begin seen[i] = tdo; tdi = 1'b0; @(negedge clk); end
            shift_en = 1'b0;
            check("R1 shift through", 64'(seen), 64'(pat));
            check("R1 no strobe", 64'({bus_wr, bus_rd}), 64'h0);
            sel = 1'b0;
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule